// File: doc/BRIEF.md
# Command Event Counter and Interrupt

This block keeps the per-channel event accounting of a DMA channel and raises the channel interrupt. Each event pulse means either that a command list was loaded or that a command finished. Every event advances a 6-bit hardware counter of finished commands, and that counter wraps modulo 64. Software keeps its own 6-bit count of the events it has handled. It writes that count back into the same register to acknowledge, and in the same write it clears an interrupt-active flag. The number of unhandled events is the difference of the two counts modulo 64.

Two registers sit on a simple word-wide read/write port. The configuration register at byte offset 0x00 holds two interrupt enables and a level/pulse select. The counter register at byte offset 0x18 holds the done count, the active flag and the processed count. The interrupt output runs either as a level, which stays up while work is pending, or as a one-cycle pulse for each enabled event. An event that lands in the same cycle as an acknowledge write is never lost.

Top module: `cmd_event_irq`

## Requirements
- R1: After reset the done count, the processed count, the active flag and all configuration bits are zero, and the interrupt output is low.
- R2: Each cycle with `evtPulse` high advances the done count (counter register bits 5:0) by one, modulo 64, so that 63 is followed by 0. The new value reads back after that clock edge.
- R3: The done count is read-only. A write to the counter register leaves bits 5:0 unchanged.
- R4: A write to the counter register loads the processed count (bits 21:16) from the written data.
- R5: An event sets the active flag (counter register bit 8) only when its kind is enabled. `evtKind` = 0 is a command completion and is enabled by configuration bit 29. `evtKind` = 1 is a list load and is enabled by configuration bit 31. A disabled event still counts but leaves the flag unchanged.
- R6: A counter register write with bit 8 = 0 clears the active flag. A write with bit 8 = 1 leaves it unchanged.
- R7: When an enabled event falls in the same cycle as a clearing write, the done count still advances and the active flag ends up set.
- R8: In level mode (configuration bit 28 = 1), `irqOut` is high while the active flag is set, or while done differs from processed and at least one of bits 29 or 31 is set. Otherwise it is low.
- R9: In pulse mode (bit 28 = 0), each enabled event drives `irqOut` high for exactly the one cycle after its clock edge. A disabled event produces no pulse.
- R10: The configuration register reads back bits 31, 29 and 28, and all its other bits read zero. The counter register bits outside 21:16, 8 and 5:0 read zero. Reads at any other address return zero, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtPulse | input | 1 | One event per cycle while high |
| evtKind | input | 1 | 0 = command completion, 1 = list load |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Byte offset of the register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| irqOut | output | 1 | Channel interrupt, level or pulse |

## Verification
Every register change, whether from an event or from a write, takes effect at the clock edge that samples the stimulus. The read port is combinational, so a new value is visible right after that edge. The level interrupt is decoded from register state and follows the same edge. The pulse interrupt comes from one flop: it is high only in the cycle after the event edge and low again after the next edge. The bench drives each stimulus for one edge, samples 1 ns after that edge, and for pulses also samples once more after the following edge.

// File: rtl/cmd_event_pkg.sv
package cmd_event_pkg;
  localparam int CNT_W     = 6;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int DONE_LSB  = 0;
  localparam int PROC_LSB  = 16;
  localparam int ACT_BIT   = 8;
  localparam int LEVEL_BIT = 28;
  localparam int IEN_BIT   = 29;
  localparam int LIEN_BIT  = 31;
  localparam logic [ADDR_W-1:0] CFG_OFFS = 8'h00;
  localparam logic [ADDR_W-1:0] CNT_OFFS = 8'h18;

  typedef struct packed {
    logic incDone;
    logic cfgWr;
    logic cntWr;
    logic setActive;
    logic clrActive;
    logic rdCfg;
    logic rdCnt;
  } evtStrobes_t;
endpackage

// File: rtl/cmd_event_ctrl.sv
module cmd_event_ctrl
  import cmd_event_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtPulse,
  input  logic              evtKind,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrActBit,
  input  logic              cfgIrqEn,
  input  logic              cfgListIrqEn,
  input  logic              cfgLevel,
  input  logic              activeFlg,
  input  logic              pendNz,
  output evtStrobes_t       strb,
  output logic              irqOut
);
  logic evtOk;
  logic pulseReg;

  assign evtOk = evtPulse && (evtKind ? cfgListIrqEn : cfgIrqEn);

  always_comb begin
    strb           = '0;
    strb.incDone   = evtPulse;
    strb.rdCfg     = (regAddr == CFG_OFFS);
    strb.rdCnt     = (regAddr == CNT_OFFS);
    strb.cfgWr     = regWrEn && strb.rdCfg;
    strb.cntWr     = regWrEn && strb.rdCnt;
    strb.setActive = evtOk;
    strb.clrActive = strb.cntWr && !wrActBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pulseReg <= 1'b0;
    else       pulseReg <= evtOk;
  end

  assign irqOut = cfgLevel ? (activeFlg || ((cfgIrqEn || cfgListIrqEn) && pendNz))
                           : pulseReg;

  // R7
  evt_beats_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtOk && strb.clrActive) |=> activeFlg);

  // R9
  pulse_follows_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtOk && !cfgLevel && !strb.cfgWr) |=> irqOut);

  // R8
  level_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLevel && !activeFlg && !pendNz) |-> !irqOut);
endmodule

// File: rtl/cmd_event_dp.sv
module cmd_event_dp
  import cmd_event_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  evtStrobes_t       strb,
  input  logic [DATA_W-1:0] regWrData,
  output logic              cfgIrqEn,
  output logic              cfgListIrqEn,
  output logic              cfgLevel,
  output logic              activeFlg,
  output logic              pendNz,
  output logic [DATA_W-1:0] regRdData
);
  logic [CNT_W-1:0]  doneCnt;
  logic [CNT_W-1:0]  procCnt;
  logic [CNT_W-1:0]  pendCnt;
  logic [DATA_W-1:0] cfgWord;
  logic [DATA_W-1:0] cntWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneCnt      <= '0;
      procCnt      <= '0;
      activeFlg    <= 1'b0;
      cfgIrqEn     <= 1'b0;
      cfgListIrqEn <= 1'b0;
      cfgLevel     <= 1'b0;
    end else begin
      if (strb.incDone) doneCnt <= doneCnt + 1'b1;
      if (strb.cntWr)   procCnt <= regWrData[PROC_LSB +: CNT_W];
      if (strb.setActive)      activeFlg <= 1'b1;
      else if (strb.clrActive) activeFlg <= 1'b0;
      if (strb.cfgWr) begin
        cfgIrqEn     <= regWrData[IEN_BIT];
        cfgListIrqEn <= regWrData[LIEN_BIT];
        cfgLevel     <= regWrData[LEVEL_BIT];
      end
    end
  end

  assign pendCnt = doneCnt - procCnt;
  assign pendNz  = (pendCnt != '0);

  always_comb begin
    cfgWord            = '0;
    cfgWord[IEN_BIT]   = cfgIrqEn;
    cfgWord[LIEN_BIT]  = cfgListIrqEn;
    cfgWord[LEVEL_BIT] = cfgLevel;
    cntWord                     = '0;
    cntWord[DONE_LSB +: CNT_W]  = doneCnt;
    cntWord[PROC_LSB +: CNT_W]  = procCnt;
    cntWord[ACT_BIT]            = activeFlg;
    if (strb.rdCfg)      regRdData = cfgWord;
    else if (strb.rdCnt) regRdData = cntWord;
    else                 regRdData = '0;
  end

  // R2
  done_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.incDone |=> doneCnt == CNT_W'($past(doneCnt) + 1'b1));

  // R3
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.incDone |=> $stable(doneCnt));

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrActive && !strb.setActive) |=> !activeFlg);
endmodule

// File: rtl/cmd_event_irq.sv
module cmd_event_irq
  import cmd_event_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtPulse,
  input  logic              evtKind,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  evtStrobes_t strb;
  logic cfgIrqEn, cfgListIrqEn, cfgLevel, activeFlg, pendNz;

  cmd_event_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .evtKind(evtKind),
    .regWrEn(regWrEn), .regAddr(regAddr), .wrActBit(regWrData[ACT_BIT]),
    .cfgIrqEn(cfgIrqEn), .cfgListIrqEn(cfgListIrqEn), .cfgLevel(cfgLevel),
    .activeFlg(activeFlg), .pendNz(pendNz), .strb(strb), .irqOut(irqOut)
  );

  cmd_event_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .cfgIrqEn(cfgIrqEn), .cfgListIrqEn(cfgListIrqEn), .cfgLevel(cfgLevel),
    .activeFlg(activeFlg), .pendNz(pendNz), .regRdData(regRdData)
  );
endmodule

// File: tb/cmd_event_irq_test.sv
`timescale 1ns/1ps
module cmd_event_irq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evtPulse = 1'b0;
  logic        evtKind = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;
  int          nChecks = 0;
  int          nFails = 0;
  logic        finished = 1'b0;

  always #5 clk = ~clk;

  cmd_event_irq uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one edge worth of stimulus, sample 1 ns after the edge
  task automatic step(logic ev, logic kind, logic wr, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    evtPulse = ev; evtKind = kind; regWrEn = wr; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    evtPulse = 1'b0; regWrEn = 1'b0;
  endtask

  function automatic logic [31:0] cntVal(int done, int proc, logic act);
    return {10'b0, 6'(proc), 7'b0, act, 2'b0, 6'(done)};
  endfunction

  task automatic readAt(logic [7:0] a, output logic [31:0] v);
    regAddr = a; #1; v = regRdData;
  endtask

  task automatic testReset();
    logic [31:0] v;
    readAt(8'h18, v); check("R1 cnt", v, 32'h0);
    readAt(8'h00, v); check("R1 cfg", v, 32'h0);
    check("R1 irq", 32'(irqOut), 32'h0);
  endtask

  task automatic testCountWrap();
    logic [31:0] v;
    step(1, 0, 0, 8'h18, 0);
    readAt(8'h18, v); check("R2 first", v, cntVal(1, 0, 0));
    check("R5 disabled no active", 32'(v[8]), 32'h0);
    for (int i = 0; i < 62; i++) step(1, i[0], 0, 8'h18, 0);
    readAt(8'h18, v); check("R2 at 63", v, cntVal(63, 0, 0));
    step(1, 0, 0, 8'h18, 0);
    readAt(8'h18, v); check("R2 wrap", v, cntVal(0, 0, 0));
  endtask

  task automatic testWriteFields();
    logic [31:0] v;
    step(0, 0, 1, 8'h18, 32'hFFFF_FEFF);
    readAt(8'h18, v); check("R3 R4 write", v, cntVal(0, 63, 0));
    step(0, 0, 1, 8'h18, 32'h0005_003F);
    readAt(8'h18, v); check("R4 load 5", v, cntVal(0, 5, 0));
    step(0, 0, 1, 8'h00, 32'hFFFF_FFFF);
    readAt(8'h00, v); check("R10 cfg bits", v, 32'hB000_0000);
    step(0, 0, 1, 8'h00, 32'h0);
    step(0, 0, 1, 8'h04, 32'hFFFF_FFFF);
    readAt(8'h04, v); check("R10 other addr", v, 32'h0);
    readAt(8'h00, v); check("R10 no side write", v, 32'h0);
    step(0, 0, 1, 8'h18, 32'h0);
  endtask

  task automatic testEnables();
    logic [31:0] v;
    // completion enable only (bit 29), pulse mode
    step(0, 0, 1, 8'h00, 32'h2000_0000);
    step(1, 1, 0, 8'h18, 0);
    readAt(8'h18, v); check("R5 list kind disabled", v, cntVal(1, 0, 0));
    check("R9 no pulse disabled", 32'(irqOut), 32'h0);
    step(1, 0, 0, 8'h18, 0);
    readAt(8'h18, v); check("R5 completion sets", v, cntVal(2, 0, 1));
    check("R9 pulse high", 32'(irqOut), 32'h1);
    @(posedge clk); #1;
    check("R9 pulse one cycle", 32'(irqOut), 32'h0);
    step(0, 0, 1, 8'h18, 32'h0002_0100);
    readAt(8'h18, v); check("R6 bit8=1 keeps", v, cntVal(2, 2, 1));
    step(0, 0, 1, 8'h18, 32'h0002_0000);
    readAt(8'h18, v); check("R6 bit8=0 clears", v, cntVal(2, 2, 0));
    // list enable only (bit 31)
    step(0, 0, 1, 8'h00, 32'h8000_0000);
    step(1, 1, 0, 8'h18, 0);
    readAt(8'h18, v); check("R5 list sets", v, cntVal(3, 2, 1));
    check("R9 list pulse", 32'(irqOut), 32'h1);
    step(0, 0, 1, 8'h18, 32'h0003_0000);
  endtask

  task automatic testLevelAndRace();
    logic [31:0] v;
    step(0, 0, 1, 8'h00, 32'h3000_0000);
    check("R8 idle low", 32'(irqOut), 32'h0);
    step(1, 0, 0, 8'h18, 0);
    check("R8 high on event", 32'(irqOut), 32'h1);
    step(0, 0, 1, 8'h18, 32'h0003_0000);
    readAt(8'h18, v); check("R6 stale ack", v, cntVal(4, 3, 0));
    check("R8 pending keeps high", 32'(irqOut), 32'h1);
    step(0, 0, 1, 8'h18, 32'h0004_0000);
    check("R8 low after full ack", 32'(irqOut), 32'h0);
    step(1, 0, 1, 8'h18, 32'h0004_0000);
    readAt(8'h18, v); check("R7 race", v, cntVal(5, 4, 1));
    check("R7 R8 irq stays", 32'(irqOut), 32'h1);
    step(0, 0, 1, 8'h18, 32'h0005_0000);
    check("R8 low again", 32'(irqOut), 32'h0);
    step(0, 0, 1, 8'h00, 32'h1000_0000);
    step(1, 0, 0, 8'h18, 0);
    check("R8 no enable no irq", 32'(irqOut), 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    testReset();
    testCountWrap();
    testWriteFields();
    testEnables();
    testLevelAndRace();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule